// File: doc/BRIEF.md
# Frame Pulse Convention Detector and Serial Bit Timer

This block sits at the front of a time-division serial port. It watches the 8 kHz frame pulse and works out by itself which convention the backplane uses: a short low pulse on a high line, or a short high pulse on a low line. No configuration is needed. Once two pulses of the same polarity have arrived exactly one frame apart, it declares frame lock and records the convention. It then supplies the strobes that the serial-to-parallel and parallel-to-serial converters run on: a transmit bit-boundary strobe, a receive sampling strobe, a start-of-frame marker, and the channel and bit position within the frame.

The block runs in a single clock domain at twice the 4.096 MHz serial clock. One tick is therefore one half-period of the serial clock, one bit cell lasts four ticks, and a frame of 32 channels by 8 bits lasts 1024 ticks. The `riseEdge` output tells which edge of the serial clock the current tick stands for. The edge that carries the bit boundary, and the one that carries the sample, follow the detected convention. With an active-low pulse, boundaries fall on falling edges and samples on rising edges. With an active-high pulse, this is reversed. The sample always sits three quarters of the way into the bit cell.

Top module: `fp_frame_timing`

## Requirements
- R1: While reset is low and after it is released, `frameLock` is 0, `modeHigh` is 0 and `txStrobe`, `rxStrobe` and `sofStrobe` are 0 until a lock is declared.
- R2: A pulse ends when the line returns to its prior level after 1 to PULSE_MAX ticks (default 3). When two active-low pulses (line idles at 1) end exactly 1024 ticks apart, `frameLock` is 1 and `modeHigh` is 0 from the tick after the second pulse ends.
- R3: When two active-high pulses (line idles at 0) end exactly 1024 ticks apart, `frameLock` is 1 and `modeHigh` is 1 from the tick after the second pulse ends.
- R4: A lone pulse, or two pulses whose ends are not exactly 1024 ticks apart, leaves `frameLock` at 0.
- R5: While locked, a pulse of the opposite polarity clears `frameLock` on the tick after it ends. A second pulse of that new polarity, one frame later, re-locks with `modeHigh` set to the new polarity.
- R6: If no pulse ends for 1024+LOSS_MARGIN ticks (default margin 8), `frameLock` falls. It is still 1 on tick offset 1032 after the last pulse end and is 0 on offset 1033. All strobes are then 0.
- R7: A level excursion longer than PULSE_MAX ticks is not a pulse. Two 4-tick excursions one frame apart do not lock. Two 3-tick pulses one frame apart do lock.
- R8: The tick after a confirming pulse end is frame tick 0. At that tick, `sofStrobe` is 1, `chanIdx` is 0 and `bitIdx` is 0. `sofStrobe` recurs every 1024 ticks.
- R9: While locked, `txStrobe` is 1 exactly on frame ticks k with k mod 4 = 0. `rxStrobe` is 1 exactly on ticks with k mod 4 = 3, three quarters into the bit cell.
- R10: `riseEdge` is 1 on ticks standing for a rising serial-clock edge. With `modeHigh`=0 it is 0 on even frame ticks (boundary on a falling edge). With `modeHigh`=1 it is 1 on even ticks. Sampling always falls on the opposite edge type.
- R11: `bitIdx` equals (k/4) mod 8 and `chanIdx` equals (k/32) mod 32 for frame tick k. Both wrap to 0 at the frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the serial clock rate |
| rstN | input | 1 | Active-low reset |
| framePulse | input | 1 | Frame pulse line, either polarity |
| frameLock | output | 1 | A valid pulse train is present and confirmed |
| modeHigh | output | 1 | Detected convention: 0 active-low, 1 active-high |
| sofStrobe | output | 1 | Frame tick 0 marker |
| txStrobe | output | 1 | Transmit bit-boundary strobe |
| rxStrobe | output | 1 | Receive sampling strobe |
| riseEdge | output | 1 | Current tick stands for a rising serial-clock edge |
| chanIdx | output | 5 | Channel position in the frame |
| bitIdx | output | 3 | Bit position in the channel, 0 sent first |

## Verification
On every cycle, the assertions check the following:
- Strobes are silent without lock.
- Transmit and sample strobes sit on the edge types that match the detected convention.
- The start-of-frame marker coincides with a zero position.
- The bit position steps once per bit cell.
- The convention changes only when lock is declared.

Only the bench scenarios can show the rest:
- The exact tick on which lock is declared or lost.
- The rejection of wide excursions and wrong spacing.
- The re-lock after a polarity change.
- That the counters follow the frame tick by tick.

// File: rtl/fp_timing_pkg.sv
package fp_timing_pkg;
  // Ticks per serial bit: two serial clock periods, two halves each.
  localparam int TICKS_PER_BIT = 4;

  typedef struct packed {
    logic align;     // confirmed pulse end: restart the frame on the next tick
    logic locked;    // frame lock held
    logic modeHigh;  // detected convention, 1 = active-high pulse
  } fpCtl_t;
endpackage

// File: rtl/fp_format_ctl.sv
module fp_format_ctl
  import fp_timing_pkg::*;
#(
  parameter int FRAME_TICKS = 1024,
  parameter int PULSE_MAX   = 3,
  parameter int LOSS_MARGIN = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   framePulse,
  output fpCtl_t ctl
);
  localparam int TIMEOUT = FRAME_TICKS + LOSS_MARGIN;
  localparam int SL_W    = $clog2(TIMEOUT + 1);
  localparam int RUN_SAT = PULSE_MAX + 1;
  localparam int RUN_W   = $clog2(RUN_SAT + 1);

  logic            fpPrev;
  logic [RUN_W-1:0] runLen;
  logic [SL_W-1:0] sinceLast;
  logic            candValid, candPol, locked, modeHigh;
  logic            lineEdge, pulseEnd, periodOk;

  assign lineEdge = framePulse != fpPrev;
  assign pulseEnd = lineEdge && (runLen != '0) && (runLen <= RUN_W'(PULSE_MAX));
  assign periodOk = candValid && (fpPrev == candPol) &&
                    (sinceLast == SL_W'(FRAME_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fpPrev    <= framePulse;
      runLen    <= RUN_W'(RUN_SAT);
      sinceLast <= SL_W'(TIMEOUT);
      candValid <= 1'b0;
      candPol   <= 1'b0;
      locked    <= 1'b0;
      modeHigh  <= 1'b0;
    end else begin
      fpPrev <= framePulse;
      if (lineEdge)
        runLen <= RUN_W'(1);
      else if (runLen != RUN_W'(RUN_SAT))
        runLen <= runLen + RUN_W'(1);

      if (pulseEnd) begin
        sinceLast <= '0;
        candPol   <= fpPrev;
        candValid <= 1'b1;
        locked    <= periodOk;
        if (periodOk) modeHigh <= fpPrev;
      end else if (sinceLast == SL_W'(TIMEOUT)) begin
        locked    <= 1'b0;
        candValid <= 1'b0;
      end else begin
        sinceLast <= sinceLast + SL_W'(1);
      end
    end
  end

  always_comb begin
    ctl.align    = pulseEnd && periodOk;
    ctl.locked   = locked;
    ctl.modeHigh = modeHigh;
  end
endmodule

// File: rtl/fp_bit_timing.sv
module fp_bit_timing
  import fp_timing_pkg::*;
#(
  parameter int CHANNELS = 32,
  parameter int BITS     = 8,
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int BIT_W   = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fpCtl_t           ctl,
  output logic             sofStrobe,
  output logic             txStrobe,
  output logic             rxStrobe,
  output logic             riseEdge,
  output logic [CH_W-1:0]  chanIdx,
  output logic [BIT_W-1:0] bitIdx
);
  localparam int PH_W   = $clog2(TICKS_PER_BIT);
  localparam int TICK_W = CH_W + BIT_W + PH_W;

  logic [TICK_W-1:0] tickCnt;
  logic [PH_W-1:0]   phase;

  always_ff @(posedge clk) begin
    if (!rstN)          tickCnt <= '0;
    else if (ctl.align) tickCnt <= '0;
    else                tickCnt <= tickCnt + TICK_W'(1);
  end

  assign phase   = tickCnt[PH_W-1:0];
  assign bitIdx  = tickCnt[PH_W +: BIT_W];
  assign chanIdx = tickCnt[PH_W + BIT_W +: CH_W];

  always_comb begin
    sofStrobe = ctl.locked && (tickCnt == '0);
    txStrobe  = ctl.locked && (phase == '0);
    rxStrobe  = ctl.locked && (phase == PH_W'(TICKS_PER_BIT - 1));
    // even ticks carry the boundary edge: falling for active-low, rising for active-high
    riseEdge  = tickCnt[0] ^ ctl.modeHigh;
  end
endmodule

// File: rtl/fp_frame_timing.sv
module fp_frame_timing
  import fp_timing_pkg::*;
#(
  parameter int CHANNELS    = 32,
  parameter int BITS        = 8,
  parameter int PULSE_MAX   = 3,
  parameter int LOSS_MARGIN = 8,
  localparam int CH_W       = $clog2(CHANNELS),
  localparam int BIT_W      = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  output logic             frameLock,
  output logic             modeHigh,
  output logic             sofStrobe,
  output logic             txStrobe,
  output logic             rxStrobe,
  output logic             riseEdge,
  output logic [CH_W-1:0]  chanIdx,
  output logic [BIT_W-1:0] bitIdx
);
  localparam int FRAME_TICKS = CHANNELS * BITS * TICKS_PER_BIT;

  fpCtl_t ctl;

  fp_format_ctl #(
    .FRAME_TICKS(FRAME_TICKS),
    .PULSE_MAX  (PULSE_MAX),
    .LOSS_MARGIN(LOSS_MARGIN)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .framePulse(framePulse),
    .ctl       (ctl)
  );

  fp_bit_timing #(
    .CHANNELS(CHANNELS),
    .BITS    (BITS)
  ) u_timing (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sofStrobe(sofStrobe),
    .txStrobe (txStrobe),
    .rxStrobe (rxStrobe),
    .riseEdge (riseEdge),
    .chanIdx  (chanIdx),
    .bitIdx   (bitIdx)
  );

  assign frameLock = ctl.locked;
  assign modeHigh  = ctl.modeHigh;
endmodule

// File: rtl/fp_frame_timing_chk.sv
module fp_frame_timing_chk #(
  parameter int CH_W  = 5,
  parameter int BIT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameLock,
  input logic             modeHigh,
  input logic             sofStrobe,
  input logic             txStrobe,
  input logic             rxStrobe,
  input logic             riseEdge,
  input logic [CH_W-1:0]  chanIdx,
  input logic [BIT_W-1:0] bitIdx
);
  // R1
  quiet_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameLock |-> !(txStrobe || rxStrobe || sofStrobe));

  // R9
  tx_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |=> !txStrobe);

  // R9
  tx_rx_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |-> !txStrobe);

  // R10
  tx_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |-> (riseEdge == modeHigh));

  // R10
  rx_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |-> (riseEdge != modeHigh));

  // R8
  sof_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofStrobe |-> (txStrobe && chanIdx == '0 && bitIdx == '0));

  // R2
  lock_aligns_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameLock) |-> sofStrobe);

  // R5
  mode_moves_on_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeHigh) |-> $rose(frameLock));

  // R11
  bit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txStrobe && !sofStrobe && $past(rxStrobe)) |-> (bitIdx == BIT_W'($past(bitIdx) + 1'b1)));
endmodule

bind fp_frame_timing fp_frame_timing_chk #(.CH_W(CH_W), .BIT_W(BIT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .frameLock(frameLock),
  .modeHigh (modeHigh),
  .sofStrobe(sofStrobe),
  .txStrobe (txStrobe),
  .rxStrobe (rxStrobe),
  .riseEdge (riseEdge),
  .chanIdx  (chanIdx),
  .bitIdx   (bitIdx)
);

// File: tb/fp_frame_timing_test.sv
`timescale 1ns/1ps
module fp_frame_timing_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       framePulse = 1'b1;
  logic       frameLock, modeHigh, sofStrobe, txStrobe, rxStrobe, riseEdge;
  logic [4:0] chanIdx;
  logic [2:0] bitIdx;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  fp_frame_timing uut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse),
    .frameLock(frameLock), .modeHigh(modeHigh), .sofStrobe(sofStrobe),
    .txStrobe(txStrobe), .rxStrobe(rxStrobe), .riseEdge(riseEdge),
    .chanIdx(chanIdx), .bitIdx(bitIdx)
  );

  always #5 clk = ~clk;

  function automatic int expTx(int k);   return (k % 4 == 0) ? 1 : 0; endfunction
  function automatic int expRx(int k);   return (k % 4 == 3) ? 1 : 0; endfunction
  function automatic int expBit(int k);  return (k / 4) % 8; endfunction
  function automatic int expChan(int k); return (k / 32) % 32; endfunction
  function automatic int expRise(int k, bit hi);
    return hi ? ((k % 2 == 0) ? 1 : 0) : ((k % 2 == 1) ? 1 : 0);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a pulse of level pol for w ticks; returns one tick after the line goes back.
  task automatic pulse(bit pol, int w);
    framePulse = pol;
    repeat (w) @(negedge clk);
    framePulse = ~pol;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Check frame ticks 0..n-1 from the current offset, ending at offset n.
  task automatic walk(bit hi, int n);
    for (int k = 0; k < n; k++) begin
      check("R9 tx",    int'(txStrobe),  expTx(k));
      check("R9 rx",    int'(rxStrobe),  expRx(k));
      check("R8 sof",   int'(sofStrobe), (k == 0) ? 1 : 0);
      check("R11 bit",  int'(bitIdx),    expBit(k));
      check("R11 chan", int'(chanIdx),   expChan(k));
      check("R10 edge", int'(riseEdge),  expRise(k, hi));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    check("R1 lock in reset", int'(frameLock), 0);
    check("R1 tx in reset",   int'(txStrobe),  0);
    rstN = 1'b1;
    idle(20);
    check("R1 lock", int'(frameLock), 0);
    check("R1 mode", int'(modeHigh),  0);
    check("R1 sof",  int'(sofStrobe), 0);
    check("R1 rx",   int'(rxStrobe),  0);

    // Active-low convention
    pulse(1'b0, 2);
    check("R4 lone pulse", int'(frameLock), 0);
    idle(1021);
    pulse(1'b0, 2);
    check("R2 lock", int'(frameLock), 1);
    check("R2 mode", int'(modeHigh),  0);
    walk(1'b0, 1021);
    pulse(1'b0, 2);
    check("R8 lock kept", int'(frameLock), 1);
    check("R8 sof again", int'(sofStrobe), 1);
    check("R8 chan zero", int'(chanIdx),   0);

    // Loss of pulse
    idle(1032);
    check("R6 still locked", int'(frameLock), 1);
    idle(1);
    check("R6 lock lost", int'(frameLock), 0);
    check("R6 tx quiet",  int'(txStrobe),  0);
    check("R6 rx quiet",  int'(rxStrobe),  0);
    check("R6 sof quiet", int'(sofStrobe), 0);

    // Wide excursions and the width limit
    pulse(1'b0, 4);
    idle(1019);
    pulse(1'b0, 4);
    check("R7 wide rejected", int'(frameLock), 0);
    idle(1100);
    pulse(1'b0, 3);
    idle(1020);
    pulse(1'b0, 3);
    check("R7 width 3 locks", int'(frameLock), 1);

    // Polarity change
    idle(100);
    framePulse = 1'b0;
    idle(100);
    pulse(1'b1, 2);
    check("R5 opposite drops", int'(frameLock), 0);
    idle(1021);
    pulse(1'b1, 2);
    check("R5 relock",   int'(frameLock), 1);
    check("R3 mode high", int'(modeHigh),  1);
    walk(1'b1, 1021);
    pulse(1'b1, 2);
    check("R3 lock kept", int'(frameLock), 1);

    // Wrong spacing
    idle(1040);
    pulse(1'b1, 2);
    idle(1022);
    pulse(1'b1, 2);
    check("R4 spacing 1025", int'(frameLock), 0);
    idle(1021);
    pulse(1'b1, 2);
    check("R4 then exact", int'(frameLock), 1);

    // Random pairs
    for (int i = 0; i < 12; i++) begin
      bit pol;
      int w1, w2, per;
      bit expLock;
      idle(1040);
      pol = 1'($urandom % 2);
      framePulse = ~pol;
      idle(20);
      w1  = 1 + int'($urandom % 5);
      w2  = 1 + int'($urandom % 5);
      per = 1024;
      if ($urandom % 3 == 0) per = 1022 + int'($urandom % 5);
      expLock = (w1 <= 3) && (w2 <= 3) && (per == 1024);
      pulse(pol, w1);
      idle(per - w2 - 1);
      pulse(pol, w2);
      check(expLock ? "R2 random lock" : "R4 random no lock", int'(frameLock), int'(expLock));
      if (expLock) begin
        check("R3 random mode", int'(modeHigh), int'(pol));
        check("R8 random sof",  int'(sofStrobe), 1);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule